// File: doc/BRIEF.md
# BFloat16 Widening Fused Multiply-Accumulate Unit

This unit performs four single-precision fused multiply-adds per issued operation on 128-bit vectors. Each source vector holds eight BFloat16 elements. A half-select input picks either the even-indexed or the odd-indexed element of each 32-bit lane. The picked elements are widened to fp32 by zero-extending their mantissa. The two widened values are multiplied, and the product is added to the fp32 accumulator element in the same lane. The exact result is rounded once, to nearest with ties to even.

The datapath is a two-stage pipeline. The first stage registers the picked elements and the accumulator. The second stage computes the four lanes and registers the results. A valid bit travels through the pipeline with the data. Subnormal operands are read as signed zero. Results too small for the normal range are flushed to signed zero. Every NaN result is the default quiet NaN. Exceptions from any lane are ORed into a four-bit sticky register. Only reset or the synchronous clear input empties that register.

Top module: `bf_wfma`

## Requirements
- R1: For result lane e (0..3), the operand element is taken from bits [32e+15:32e] when `half_sel`=0 and from bits [32e+31:32e+16] when `half_sel`=1, in both `src_a` and `src_b`; the other half has no effect on lane e.
- R2: The accumulator addend for lane e is `acc[32e+31:32e]`, and the result of lane e appears on `result[32e+31:32e]`; lanes are independent.
- R3: The value a*b+c is computed exactly and rounded once to nearest, ties to even; the inexact flag is set when rounding discards nonzero bits.
- R4: `out_valid` is high exactly two clock cycles after `in_valid` was sampled high, with `result` valid in that same cycle, and is low otherwise.
- R5: A BF16 or fp32 operand with a zero exponent field counts as a zero of its sign. A nonzero result whose exponent before rounding is below 1 becomes a zero with the sign of the exact result, and raises underflow and inexact. No subnormal is ever produced.
- R6: A rounded result whose exponent reaches 255 becomes an infinity with the sign of the exact result, and raises overflow and inexact.
- R7: Every NaN result is 0x7FC00000. Invalid is raised for infinity times zero, for infinities of opposite sign meeting in the addition, and for any signalling NaN operand (NaN with mantissa MSB clear). A quiet NaN operand gives the default NaN without invalid.
- R8: An exact zero sum is +0, except when the product and the addend are both zeros of negative sign, which gives -0.
- R9: `sticky_flags` bit 0 is invalid, bit 1 overflow, bit 2 underflow, bit 3 inexact. Each bit is the OR over all lanes of all completed results since the last clear or reset. Bits rise only in a cycle where `out_valid` is high.
- R10: When `flag_clear` is high, the flags of earlier results are dropped. The flags of a result that completes in the same cycle are kept, so after that edge the register holds only those new flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Issues an operation this cycle |
| half_sel | input | 1 | 0 selects even BF16 elements, 1 selects odd |
| src_a | input | 128 | First BF16 source vector |
| src_b | input | 128 | Second BF16 source vector |
| acc | input | 128 | fp32 accumulator vector, four lanes |
| flag_clear | input | 1 | Synchronous clear of the sticky flags |
| out_valid | output | 1 | Result valid |
| result | output | 128 | fp32 result vector, four lanes |
| sticky_flags | output | 4 | Sticky {inexact, underflow, overflow, invalid} |

## Verification
The clear input and the arrival of a result that raises flags can fall on the same clock edge. In that case the old flags must disappear and the new ones must survive. The bench first fills the sticky register through an overflowing operation. It then issues an inexact operation and holds `flag_clear` high in exactly the cycle its result is registered. The register must then read the inexact bit alone, with no trace of the overflow. A clear with no result in flight must leave all zeros.

// File: rtl/bf_wfma_pkg.sv
package bf_wfma_pkg;
  localparam int ELEM_W = 16;
  localparam int LANE_W = 32;
  localparam int FLAG_W = 4;
  localparam int FL_NV = 0;
  localparam int FL_OF = 1;
  localparam int FL_UF = 2;
  localparam int FL_IX = 3;
  localparam logic [LANE_W-1:0] QNAN_DEFAULT = 32'h7FC0_0000;
endpackage

// File: rtl/bf_lane_pick.sv
module bf_lane_pick #(
  parameter int LANES = 4
) (
  input  logic                  half_sel,
  input  logic [LANES*32-1:0]   vec_a,
  input  logic [LANES*32-1:0]   vec_b,
  output logic [LANES*16-1:0]   pick_a,
  output logic [LANES*16-1:0]   pick_b
);
  for (genvar e = 0; e < LANES; e++) begin : g_lane
    assign pick_a[e*16 +: 16] = half_sel ? vec_a[e*32+16 +: 16] : vec_a[e*32 +: 16];
    assign pick_b[e*16 +: 16] = half_sel ? vec_b[e*32+16 +: 16] : vec_b[e*32 +: 16];
  end
endmodule

// File: rtl/bf_fma_lane.sv
module bf_fma_lane
  import bf_wfma_pkg::*;
(
  input  logic [15:0] op_a,
  input  logic [15:0] op_b,
  input  logic [31:0] addend,
  output logic [31:0] res,
  output logic [FLAG_W-1:0] flags
);
  localparam int SIG_W = 24;
  localparam int GRD   = 26;
  localparam int FRM_W = SIG_W + GRD + 1;
  localparam int EXP_W = 12;

  function automatic logic [FRM_W-1:0] shr_sticky(input logic [FRM_W-1:0] v,
                                                  input logic [EXP_W-1:0] d);
    logic [FRM_W-1:0] mask;
    if (d >= EXP_W'(FRM_W)) return {{(FRM_W-1){1'b0}}, |v};
    mask = ~({FRM_W{1'b1}} << d);
    return (v >> d) | {{(FRM_W-1){1'b0}}, |(v & mask)};
  endfunction

  logic a_zero, b_zero, c_zero, a_inf, b_inf, c_inf, a_nan, b_nan, c_nan;
  logic snan, p_zero, p_inf, sp, sc, rsign;
  logic [15:0] prod;
  logic [SIG_W-1:0] psig, csig;
  logic signed [EXP_W-1:0] pexp, cexp, big_exp, diff, rexp, fexp;
  logic [FRM_W-1:0] fp, fc, sum, norm;
  logic [5:0] lead;
  logic [SIG_W-1:0] kept;
  logic rbit, stk, rup;
  logic [SIG_W:0] rnd;
  logic [22:0] mant;
  logic [31:0] n_res;
  logic [FLAG_W-1:0] n_flags;

  always_comb begin
    a_zero = (op_a[14:7] == 8'd0);
    b_zero = (op_b[14:7] == 8'd0);
    c_zero = (addend[30:23] == 8'd0);
    a_inf  = (op_a[14:7] == 8'hFF) && (op_a[6:0] == 7'd0);
    b_inf  = (op_b[14:7] == 8'hFF) && (op_b[6:0] == 7'd0);
    c_inf  = (addend[30:23] == 8'hFF) && (addend[22:0] == 23'd0);
    a_nan  = (op_a[14:7] == 8'hFF) && (op_a[6:0] != 7'd0);
    b_nan  = (op_b[14:7] == 8'hFF) && (op_b[6:0] != 7'd0);
    c_nan  = (addend[30:23] == 8'hFF) && (addend[22:0] != 23'd0);
    snan   = (a_nan && !op_a[6]) || (b_nan && !op_b[6]) || (c_nan && !addend[22]);
    p_zero = a_zero || b_zero;
    p_inf  = a_inf || b_inf;
    sp     = op_a[15] ^ op_b[15];
    sc     = addend[31];

    // exact product of the 8-bit significands, widened into the 24-bit frame
    prod = {8'd0, 1'b1, op_a[6:0]} * {8'd0, 1'b1, op_b[6:0]};
    psig = p_zero ? '0 : {prod, 8'd0};
    pexp = p_zero ? -12'sd1024 :
           $signed({4'd0, op_a[14:7]}) + $signed({4'd0, op_b[14:7]}) - 12'sd126;
    csig = c_zero ? '0 : {1'b1, addend[22:0]};
    cexp = c_zero ? -12'sd1024 : $signed({4'd0, addend[30:23]});

    // align the operand with the smaller exponent, folding lost bits into bit 0
    fp = {1'b0, psig, {GRD{1'b0}}};
    fc = {1'b0, csig, {GRD{1'b0}}};
    if (pexp >= cexp) begin
      big_exp = pexp;
      diff    = pexp - cexp;
      fc      = shr_sticky(fc, diff);
    end else begin
      big_exp = cexp;
      diff    = cexp - pexp;
      fp      = shr_sticky(fp, diff);
    end

    if (sp == sc) begin
      sum = fp + fc;  rsign = sp;
    end else if (fp >= fc) begin
      sum = fp - fc;  rsign = sp;
    end else begin
      sum = fc - fp;  rsign = sc;
    end

    lead = '0;
    for (int i = 0; i < FRM_W; i++) if (sum[i]) lead = 6'(i);
    norm = sum << (6'(FRM_W-1) - lead);
    kept = norm[FRM_W-1 -: SIG_W];
    rbit = norm[GRD];
    stk  = |norm[GRD-1:0];
    rexp = big_exp + $signed({6'd0, lead}) - 12'sd49;
    rup  = rbit && (stk || kept[0]);
    rnd  = {1'b0, kept} + (SIG_W+1)'(rup);
    fexp = rnd[SIG_W] ? rexp + 12'sd1 : rexp;
    mant = rnd[SIG_W] ? rnd[23:1] : rnd[22:0];

    n_flags = '0;
    if (sum == '0) begin
      n_res = {sp & sc, 31'd0};
    end else if (rexp <= 12'sd0) begin
      n_res = {rsign, 31'd0};
      n_flags[FL_UF] = 1'b1;
      n_flags[FL_IX] = 1'b1;
    end else if (fexp >= 12'sd255) begin
      n_res = {rsign, 8'hFF, 23'd0};
      n_flags[FL_OF] = 1'b1;
      n_flags[FL_IX] = 1'b1;
    end else begin
      n_res = {rsign, fexp[7:0], mant};
      n_flags[FL_IX] = rbit | stk;
    end

    flags = '0;
    if (a_nan || b_nan || c_nan) begin
      res = QNAN_DEFAULT;
      flags[FL_NV] = snan;
    end else if (p_inf && p_zero) begin
      res = QNAN_DEFAULT;
      flags[FL_NV] = 1'b1;
    end else if (p_inf && c_inf && (sp != sc)) begin
      res = QNAN_DEFAULT;
      flags[FL_NV] = 1'b1;
    end else if (p_inf) begin
      res = {sp, 8'hFF, 23'd0};
    end else if (c_inf) begin
      res = {sc, 8'hFF, 23'd0};
    end else begin
      res   = n_res;
      flags = n_flags;
    end
  end
endmodule

// File: rtl/bf_wfma.sv
module bf_wfma
  import bf_wfma_pkg::*;
#(
  parameter  int LANES = 4,
  localparam int VEC_W = LANES * LANE_W,
  localparam int PCK_W = LANES * ELEM_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic              half_sel,
  input  logic [VEC_W-1:0]  src_a,
  input  logic [VEC_W-1:0]  src_b,
  input  logic [VEC_W-1:0]  acc,
  input  logic              flag_clear,
  output logic              out_valid,
  output logic [VEC_W-1:0]  result,
  output logic [FLAG_W-1:0] sticky_flags
);
  logic [PCK_W-1:0]  pick_a, pick_b;
  logic              s1_valid;
  logic [PCK_W-1:0]  s1_a, s1_b;
  logic [VEC_W-1:0]  s1_c;
  logic [VEC_W-1:0]  lane_res;
  logic [LANES*FLAG_W-1:0] lane_flags;
  logic [FLAG_W-1:0] any_flags;

  bf_lane_pick #(.LANES(LANES)) u_pick (
    .half_sel (half_sel),
    .vec_a    (src_a),
    .vec_b    (src_b),
    .pick_a   (pick_a),
    .pick_b   (pick_b)
  );

  always_ff @(posedge clk) begin
    if (rst) s1_valid <= 1'b0;
    else     s1_valid <= in_valid;
    s1_a <= pick_a;
    s1_b <= pick_b;
    s1_c <= acc;
  end

  for (genvar e = 0; e < LANES; e++) begin : g_fma
    bf_fma_lane u_lane (
      .op_a   (s1_a[e*ELEM_W +: ELEM_W]),
      .op_b   (s1_b[e*ELEM_W +: ELEM_W]),
      .addend (s1_c[e*LANE_W +: LANE_W]),
      .res    (lane_res[e*LANE_W +: LANE_W]),
      .flags  (lane_flags[e*FLAG_W +: FLAG_W])
    );
  end

  always_comb begin
    any_flags = '0;
    for (int e = 0; e < LANES; e++) any_flags |= lane_flags[e*FLAG_W +: FLAG_W];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid    <= 1'b0;
      sticky_flags <= '0;
    end else begin
      out_valid    <= s1_valid;
      sticky_flags <= (flag_clear ? '0 : sticky_flags) | (s1_valid ? any_flags : '0);
    end
    result <= lane_res;
  end
endmodule

// File: rtl/bf_wfma_chk.sv
module bf_wfma_chk
  import bf_wfma_pkg::*;
#(
  parameter int LANES = 4
) (
  input logic                     clk,
  input logic                     rst,
  input logic                     in_valid,
  input logic                     flag_clear,
  input logic                     out_valid,
  input logic [LANES*LANE_W-1:0]  result,
  input logic [FLAG_W-1:0]        sticky_flags
);
  logic past_ok;
  logic bad_nan, subnorm;

  always_ff @(posedge clk) begin
    if (rst) past_ok <= 1'b0;
    else     past_ok <= 1'b1;
  end

  always_comb begin
    bad_nan = 1'b0;
    subnorm = 1'b0;
    for (int e = 0; e < LANES; e++) begin
      if (result[e*LANE_W+23 +: 8] == 8'hFF && result[e*LANE_W +: 23] != 23'd0 &&
          result[e*LANE_W +: LANE_W] != QNAN_DEFAULT) bad_nan = 1'b1;
      if (result[e*LANE_W+23 +: 8] == 8'd0 && result[e*LANE_W +: 23] != 23'd0) subnorm = 1'b1;
    end
  end

  AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> ##1 out_valid); // R4
  AST_VALID_NO_SPURIOUS: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> ##1 !out_valid); // R4
  AST_NAN_IS_DEFAULT: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> !bad_nan); // R7
  AST_NO_SUBNORMAL_OUT: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> !subnorm); // R5
  AST_STICKY_HOLDS: assert property (@(posedge clk) disable iff (rst)
    (past_ok && !$past(flag_clear)) |-> ((sticky_flags & $past(sticky_flags)) == $past(sticky_flags))); // R9
  AST_STICKY_RISES_ON_RESULT: assert property (@(posedge clk) disable iff (rst)
    (past_ok && ((sticky_flags & ~$past(sticky_flags)) != '0)) |-> out_valid); // R9
  AST_CLEAR_EMPTIES: assert property (@(posedge clk) disable iff (rst)
    flag_clear |=> (sticky_flags == '0 || out_valid)); // R10
endmodule

bind bf_wfma bf_wfma_chk #(.LANES(LANES)) u_chk (
  .clk          (clk),
  .rst          (rst),
  .in_valid     (in_valid),
  .flag_clear   (flag_clear),
  .out_valid    (out_valid),
  .result       (result),
  .sticky_flags (sticky_flags)
);

// File: tb/tb_bf_wfma.sv
module tb_bf_wfma;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_valid = 1'b0;
  logic half_sel = 1'b0;
  logic [127:0] src_a = '0, src_b = '0, acc = '0;
  logic flag_clear = 1'b0;
  logic out_valid;
  logic [127:0] result;
  logic [3:0] sticky_flags;

  int checks = 0;
  int failures = 0;
  logic [3:0] exp_sticky = '0;
  logic [31:0] rng = 32'h1234_5678;

  always #5 clk = ~clk;

  bf_wfma dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .half_sel(half_sel),
    .src_a(src_a), .src_b(src_b), .acc(acc), .flag_clear(flag_clear),
    .out_valid(out_valid), .result(result), .sticky_flags(sticky_flags)
  );

  task automatic check(input bit ok, input string req, input logic [127:0] act, input logic [127:0] expv);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, expv);
    end
  endtask

  function automatic real f32r(input logic [31:0] f);
    logic [10:0] e = 11'({3'b0, f[30:23]}) + 11'd896;
    return $bitstoreal({f[31], e, f[22:0], 29'd0});
  endfunction

  // exact real value rounded to fp32, nearest-even, flush below normal range
  function automatic logic [35:0] round32(input real v);
    logic [63:0] d = $realtobits(v);
    int e = int'(d[62:52]) - 896;
    logic [23:0] k = {1'b1, d[51:29]};
    logic rb = d[28];
    logic st = |d[27:0];
    logic [24:0] r;
    if (e <= 0) return {4'b1100, d[63], 31'd0};
    r = {1'b0, k} + 25'(rb && (st || k[0]));
    if (r[24]) begin e = e + 1; r = 25'd0; end
    if (e >= 255) return {4'b1010, d[63], 8'hFF, 23'd0};
    return {rb | st, 3'b000, d[63], 8'(e), r[22:0]};
  endfunction

  function automatic logic [35:0] model_lane(input logic [15:0] a, input logic [15:0] b, input logic [31:0] c);
    bit an = a[14:7] == 8'hFF && a[6:0] != 0;
    bit bn = b[14:7] == 8'hFF && b[6:0] != 0;
    bit cn = c[30:23] == 8'hFF && c[22:0] != 0;
    bit sn = (an && !a[6]) || (bn && !b[6]) || (cn && !c[22]);
    bit ai = a[14:7] == 8'hFF && a[6:0] == 0;
    bit bi = b[14:7] == 8'hFF && b[6:0] == 0;
    bit ci = c[30:23] == 8'hFF && c[22:0] == 0;
    bit az = a[14:7] == 0, bz = b[14:7] == 0, cz = c[30:23] == 0;
    bit sp = a[15] ^ b[15];
    real v;
    if (an || bn || cn) return {3'b000, sn, 32'h7FC0_0000};
    if ((ai || bi) && (az || bz)) return {4'b0001, 32'h7FC0_0000};
    if ((ai || bi) && ci && sp != c[31]) return {4'b0001, 32'h7FC0_0000};
    if (ai || bi) return {4'b0000, sp, 8'hFF, 23'd0};
    if (ci) return {4'b0000, c[31], 8'hFF, 23'd0};
    v = ((az || bz) ? 0.0 : f32r({a, 16'd0}) * f32r({b, 16'd0})) + (cz ? 0.0 : f32r(c));
    if (v == 0.0) return {4'b0000, sp & c[31], 31'd0};
    return round32(v);
  endfunction

  task automatic do_op(input logic [127:0] a, input logic [127:0] b, input logic [127:0] c,
                       input bit sel, input bit clr_at_out, input string req);
    logic [127:0] expv;
    logic [3:0] fl = '0;
    for (int e = 0; e < 4; e++) begin
      logic [35:0] m = model_lane(a[e*32 + 16*sel +: 16], b[e*32 + 16*sel +: 16], c[e*32 +: 32]);
      expv[e*32 +: 32] = m[31:0];
      fl |= m[35:32];
    end
    @(negedge clk);
    src_a = a; src_b = b; acc = c; half_sel = sel; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    src_a = ~a; src_b = ~b; acc = ~c; half_sel = ~sel;
    check(out_valid == 1'b0, "R4 early valid", {127'd0, out_valid}, 128'd0);
    if (clr_at_out) flag_clear = 1'b1;
    @(negedge clk);
    flag_clear = 1'b0;
    exp_sticky = (clr_at_out ? 4'd0 : exp_sticky) | fl;
    check(out_valid == 1'b1, "R4 valid", {127'd0, out_valid}, 128'd1);
    check(result === expv, req, result, expv);
    check(sticky_flags === exp_sticky, clr_at_out ? "R10 sticky" : "R9 sticky",
          {124'd0, sticky_flags}, {124'd0, exp_sticky});
  endtask

  task automatic clear_flags();
    @(negedge clk); flag_clear = 1'b1;
    @(negedge clk); flag_clear = 1'b0;
    exp_sticky = '0;
    check(sticky_flags == 4'd0, "R9 clear", {124'd0, sticky_flags}, 128'd0);
  endtask

  // selected half carries v, the other half a signalling NaN (R1)
  function automatic logic [127:0] rep_bf(input logic [15:0] v, input bit sel);
    logic [127:0] r;
    for (int e = 0; e < 4; e++) r[e*32 +: 32] = sel ? {v, 16'h7F81} : {16'h7F81, v};
    return r;
  endfunction

  function automatic logic [127:0] rep32(input logic [31:0] v);
    return {v, v, v, v};
  endfunction

  function automatic logic [31:0] nxt();
    rng ^= rng << 13; rng ^= rng >> 17; rng ^= rng << 5;
    return rng;
  endfunction

  function automatic logic [15:0] rnd_bf();
    logic [31:0] r = nxt();
    if (r[31:28] == 4'd0) return {r[0], 15'd0};
    return {r[0], 8'(8'd120 + r[8:1] % 15), r[15:9]};
  endfunction

  function automatic logic [31:0] rnd_f32();
    logic [31:0] r = nxt();
    logic [31:0] s = nxt();
    if (r[31:28] == 4'd0) return {r[0], 31'd0};
    return {r[0], 8'(8'd120 + r[8:1] % 21), s[22:0]};
  endfunction

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check(out_valid == 1'b0, "R4 reset valid", {127'd0, out_valid}, 128'd0);
    check(sticky_flags == 4'd0, "R9 reset flags", {124'd0, sticky_flags}, 128'd0);

    // R1 R2 basic, both halves
    do_op(rep_bf(16'h3FC0, 0), rep_bf(16'h4000, 0), rep32(32'h3E80_0000), 0, 0, "R1 even 1.5*2+0.25");
    do_op(rep_bf(16'h3FC0, 1), rep_bf(16'hC000, 1), rep32(32'h3E80_0000), 1, 0, "R1 odd 1.5*-2+0.25");
    // R3 ties and above-tie
    clear_flags();
    do_op(rep_bf(16'h3380, 0), rep_bf(16'h3F80, 0), rep32(32'h3F80_0000), 0, 0, "R3 tie stays even");
    do_op(rep_bf(16'h3380, 1), rep_bf(16'h3F80, 1), rep32(32'h3F80_0001), 1, 0, "R3 tie rounds to even up");
    do_op(rep_bf(16'h3380, 0), rep_bf(16'h3F81, 0), rep32(32'h3F80_0000), 0, 0, "R3 above tie rounds up");
    // R6 overflow
    clear_flags();
    do_op(rep_bf(16'h7F00, 0), rep_bf(16'h4000, 0), rep32(32'h0), 0, 0, "R6 overflow +inf");
    do_op(rep_bf(16'hFF00, 1), rep_bf(16'h4000, 1), rep32(32'h0), 1, 0, "R6 overflow -inf");
    // R5 flush
    clear_flags();
    do_op(rep_bf(16'h0100, 0), rep_bf(16'h3E80, 0), rep32(32'h0), 0, 0, "R5 tiny flushed");
    do_op(rep_bf(16'h8100, 0), rep_bf(16'h3E80, 0), rep32(32'h0), 0, 0, "R5 tiny flushed negative");
    clear_flags();
    do_op(rep_bf(16'h0001, 1), rep_bf(16'h3F80, 1), rep32(32'h3F80_0000), 1, 0, "R5 subnormal input");
    do_op(rep_bf(16'h3F80, 0), rep_bf(16'h3F80, 0), rep32(32'h0000_0001), 0, 0, "R5 subnormal addend");
    // R7 NaN handling
    clear_flags();
    do_op(rep_bf(16'h7FC0, 0), rep_bf(16'h3F80, 0), rep32(32'h3F80_0000), 0, 0, "R7 quiet NaN");
    do_op(rep_bf(16'h7F80, 0), rep_bf(16'h0000, 0), rep32(32'h3F80_0000), 0, 0, "R7 inf times zero");
    clear_flags();
    do_op(rep_bf(16'h7F80, 1), rep_bf(16'h3F80, 1), rep32(32'hFF80_0000), 1, 0, "R7 inf minus inf");
    clear_flags();
    do_op(rep_bf(16'h3F80, 0), rep_bf(16'h7F81, 0), rep32(32'h3F80_0000), 0, 0, "R7 signalling NaN bf16");
    clear_flags();
    do_op(rep_bf(16'h3F80, 0), rep_bf(16'h3F80, 0), rep32(32'h7F80_0001), 0, 0, "R7 signalling NaN addend");
    do_op(rep_bf(16'h7F80, 0), rep_bf(16'hBF80, 0), rep32(32'h3F80_0000), 0, 0, "R7 signed inf passes");
    // R8 zero signs
    clear_flags();
    do_op(rep_bf(16'h3F80, 0), rep_bf(16'h3F80, 0), rep32(32'hBF80_0000), 0, 0, "R8 cancellation +0");
    do_op(rep_bf(16'h8000, 1), rep_bf(16'h3F80, 1), rep32(32'h8000_0000), 1, 0, "R8 -0 plus -0");
    do_op(rep_bf(16'h0000, 0), rep_bf(16'h3F80, 0), rep32(32'h8000_0000), 0, 0, "R8 +0 plus -0");
    // R10 clear coinciding with a completing result
    do_op(rep_bf(16'h7F00, 0), rep_bf(16'h4000, 0), rep32(32'h0), 0, 0, "R6 fill flags");
    do_op(rep_bf(16'h3380, 0), rep_bf(16'h3F80, 0), rep32(32'h3F80_0000), 0, 1, "R10 clear with result");
    clear_flags();

    // R2 R3 sweep over random lanes with exact reference sums
    for (int i = 0; i < 400; i++) begin
      logic [127:0] a, b, c;
      bit sel;
      for (int e = 0; e < 8; e++) begin
        a[e*16 +: 16] = rnd_bf();
        b[e*16 +: 16] = rnd_bf();
      end
      for (int e = 0; e < 4; e++) c[e*32 +: 32] = rnd_f32();
      sel = nxt() & 1;
      do_op(a, b, c, sel, (i % 50) == 49, "R2 R3 sweep lane result");
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule